// File: doc/BRIEF.md
# Sixteen-Source Prioritized Interrupt Controller

This block gathers sixteen interrupt request lines into one interrupt output for a processor. Each line is set up on its own as level- or edge-sensitive, with a chosen active polarity. Captured requests are held in a pending register. A mask register hides pending sources from arbitration. An in-service register records which sources the processor is handling at the moment.

Priority follows a rotating scan. The scan starts at the position marked by a one-hot first-priority register and moves upward through the sources, wrapping from 15 back to 0. In fixed mode, an in-service source blocks every source of lower priority. A source marked as cascade may interrupt again while it is still in service. In the other mode, any source in service blocks every request.

The processor pulses an acknowledge strobe. The controller then returns the index of the winning source, marks that source as in service and drops the interrupt output. A write to the end-of-interrupt address retires the highest-priority source in service. All configuration goes through byte-wide writes and byte-wide combinational reads.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, int_o is 0. The pending and in-service registers are all zero. The mask (addresses 2/3) and polarity (addresses 6/7) registers read 0xFF. The first-priority register (addresses 10/11) holds 0x0001. The mode register (address 12) is 0.
- R2: A source whose trigger bit is 1 (addresses 4/5) is level-sensitive. Its pending bit is set on each clock while the line is active, unless freeze (mode bit 1) is 1. It is cleared on each clock while the line is inactive. A line is active when it equals its polarity bit, where 1 means active high.
- R3: A source whose trigger bit is 0 is edge-sensitive. Its pending bit is set only on a change of the line into the active level. A line held active does not set the bit again after the bit has been cleared.
- R4: A byte write to address 0 (low half) or address 1 (high half) is a pending command. Data bit 6 clears all eight bits of that half. Otherwise, data bit 7 sets pending bit data[3:0]. Otherwise, pending bit data[3:0] is cleared. A command takes effect after line capture in the same clock.
- R5: ack_vec_o gives the first unmasked pending source met by a scan that starts at the lowest set bit of the first-priority register and moves upward with wrap. The value is {4'h0, index}. It is 0xFF when no unmasked source is pending.
- R6: On a clock with ack_i high, the selected source's in-service bit is set (read at addresses 14/15). Its pending bit is cleared if the source is edge-sensitive or its line is inactive. A level source with an active line stays pending.
- R7: In fixed mode (mode bit 0 = 1) with sources in service, an interrupt is requested only in two cases. Either an unmasked pending source comes before the first in-service position in the scan, or the source at that in-service position has its cascade bit set (addresses 8/9) and is pending and unmasked.
- R8: In the other mode (mode bit 0 = 0), an interrupt is requested exactly when some unmasked source is pending and no source is in service.
- R9: int_o is registered. It goes to 0 on the clock edge that sees ack_i. Otherwise it follows the request computed from the register state, one clock after that state changes.
- R10: A write to address 13 clears the in-service bit met first by the rotating priority scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 16 | Interrupt request lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Write address |
| reg_wdata_i | input | 8 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 8 | Read data, combinational |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| ack_vec_o | output | 8 | Acknowledge vector, combinational |
| int_o | output | 1 | Interrupt request to the processor |

## Verification
A corrupted pending or in-service bit appears on ack_vec_o right away, because the vector is combinational. It appears on int_o one clock later. A scan that mishandles the rotation or the wrap returns the wrong index as soon as the first-priority register points past a pending source. The bench therefore walks several start positions, masks and pending patterns. A fault in the nesting or cascade logic shows as int_o being wrongly high or low on the clock after the pending or in-service state changes.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
  localparam int unsigned SRC_N  = 16;
  localparam int unsigned IDX_W  = $clog2(SRC_N);
  localparam int unsigned HALF_N = SRC_N / 2;

  typedef enum logic [3:0] {
    A_PEND_LO = 4'd0,  A_PEND_HI = 4'd1,
    A_MASK_LO = 4'd2,  A_MASK_HI = 4'd3,
    A_TRIG_LO = 4'd4,  A_TRIG_HI = 4'd5,
    A_POL_LO  = 4'd6,  A_POL_HI  = 4'd7,
    A_CASC_LO = 4'd8,  A_CASC_HI = 4'd9,
    A_FPRI_LO = 4'd10, A_FPRI_HI = 4'd11,
    A_MODE    = 4'd12, A_EOI     = 4'd13,
    A_INSV_LO = 4'd14, A_INSV_HI = 4'd15
  } reg_addr_e;

  localparam int unsigned MODE_FIXED  = 0;
  localparam int unsigned MODE_FREEZE = 1;
  localparam int unsigned CMD_CLR_ALL = 6;
  localparam int unsigned CMD_SET     = 7;
endpackage

// File: rtl/ictl_scan.sv
// Rotating first-set search; N must be a power of two so the index wraps naturally.
module ictl_scan #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  start_oh_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] start;

  always_comb begin
    start = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (start_oh_i[i]) start = IW'(i);
    end
  end

  always_comb begin
    logic [IW-1:0] pos;
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < N; k++) begin
      pos = start + IW'(k);
      if (!found_o && req_i[pos]) begin
        found_o = 1'b1;
        idx_o   = pos;
      end
    end
  end
endmodule

// File: rtl/ictl_resolve.sv
module ictl_resolve #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  mask_i,
  input  logic [N-1:0]  insv_i,
  input  logic [N-1:0]  casc_i,
  input  logic [N-1:0]  fpri_i,
  input  logic          fixed_i,
  output logic          req_o,
  output logic          sel_found_o,
  output logic [IW-1:0] sel_idx_o,
  output logic          eoi_found_o,
  output logic [IW-1:0] eoi_idx_o
);
  logic [N-1:0]  unm;
  logic          stop_found;
  logic [IW-1:0] stop_idx;

  assign unm = pend_i & ~mask_i;

  ictl_scan #(.N(N), .IW(IW)) u_sel (
    .req_i(unm), .start_oh_i(fpri_i), .found_o(sel_found_o), .idx_o(sel_idx_o)
  );

  // first position that is either in service or requesting
  ictl_scan #(.N(N), .IW(IW)) u_stop (
    .req_i(unm | insv_i), .start_oh_i(fpri_i), .found_o(stop_found), .idx_o(stop_idx)
  );

  ictl_scan #(.N(N), .IW(IW)) u_eoi (
    .req_i(insv_i), .start_oh_i(fpri_i), .found_o(eoi_found_o), .idx_o(eoi_idx_o)
  );

  always_comb begin
    req_o = 1'b0;
    if (|unm) begin
      if (!(|insv_i))          req_o = 1'b1;
      else if (fixed_i && stop_found) begin
        if (insv_i[stop_idx])  req_o = casc_i[stop_idx] & unm[stop_idx];
        else                   req_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ictl_pend.sv
module ictl_pend #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N),
  localparam int unsigned HN = N / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_i,
  input  logic [N-1:0]  trig_i,
  input  logic [N-1:0]  pol_i,
  input  logic          freeze_i,
  input  logic [N-1:0]  ack_oh_i,
  input  logic          cmd_we_i,
  input  logic          cmd_hi_i,
  input  logic          cmd_clr_all_i,
  input  logic          cmd_set_i,
  input  logic [IW-1:0] cmd_idx_i,
  output logic [N-1:0]  pend_o
);
  logic [N-1:0] line_q, pend_q, pend_n, active, edge_hit;

  assign active   = ~(irq_i ^ pol_i);
  assign edge_hit = active & (irq_i ^ line_q);

  always_comb begin
    pend_n = pend_q;
    for (int i = 0; i < N; i++) begin
      if (trig_i[i]) begin
        if (!active[i])     pend_n[i] = 1'b0;
        else if (!freeze_i) pend_n[i] = 1'b1;
      end else if (edge_hit[i]) begin
        pend_n[i] = 1'b1;
      end
    end
    // level sources with an active line survive acknowledge
    pend_n = pend_n & ~(ack_oh_i & (~trig_i | ~active));
    if (cmd_we_i) begin
      if (cmd_clr_all_i) begin
        if (cmd_hi_i) pend_n[N-1:HN] = '0;
        else          pend_n[HN-1:0] = '0;
      end else begin
        pend_n[cmd_idx_i] = cmd_set_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      line_q <= '0;
    end else begin
      pend_q <= pend_n;
      line_q <= irq_i;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import ictl_pkg::*;
#(
  parameter int unsigned VEC_W       = 8,
  parameter logic [7:0]  DEFAULT_VEC = 8'hFF,
  parameter logic [15:0] FPRI_RST    = 16'h0001
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] irq_i,
  input  logic        reg_we_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  input  logic [3:0]  rd_addr_i,
  output logic [7:0]  rd_data_o,
  input  logic        ack_i,
  output logic [7:0]  ack_vec_o,
  output logic        int_o
);
  localparam int unsigned N  = SRC_N;
  localparam int unsigned IW = IDX_W;

  reg_addr_e      waddr, raddr;
  logic [N-1:0]   mask_q, trig_q, pol_q, casc_q, fpri_q, insv_q, pend_w;
  logic [1:0]     mode_q;
  logic           int_q, req;
  logic           sel_found, eoi_found;
  logic [IW-1:0]  sel_idx, eoi_idx;
  logic [N-1:0]   ack_oh, eoi_oh;
  logic           pend_cmd;

  assign waddr    = reg_addr_e'(reg_addr_i);
  assign raddr    = reg_addr_e'(rd_addr_i);
  assign pend_cmd = reg_we_i && (waddr == A_PEND_LO || waddr == A_PEND_HI);
  assign ack_oh   = (ack_i && sel_found) ? (N'(1) << sel_idx) : '0;
  assign eoi_oh   = (reg_we_i && waddr == A_EOI && eoi_found) ? (N'(1) << eoi_idx) : '0;

  ictl_pend #(.N(N), .IW(IW)) u_pend (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .irq_i         (irq_i),
    .trig_i        (trig_q),
    .pol_i         (pol_q),
    .freeze_i      (mode_q[MODE_FREEZE]),
    .ack_oh_i      (ack_oh),
    .cmd_we_i      (pend_cmd),
    .cmd_hi_i      (reg_addr_i[0]),
    .cmd_clr_all_i (reg_wdata_i[CMD_CLR_ALL]),
    .cmd_set_i     (reg_wdata_i[CMD_SET]),
    .cmd_idx_i     (reg_wdata_i[IW-1:0]),
    .pend_o        (pend_w)
  );

  ictl_resolve #(.N(N), .IW(IW)) u_resolve (
    .pend_i      (pend_w),
    .mask_i      (mask_q),
    .insv_i      (insv_q),
    .casc_i      (casc_q),
    .fpri_i      (fpri_q),
    .fixed_i     (mode_q[MODE_FIXED]),
    .req_o       (req),
    .sel_found_o (sel_found),
    .sel_idx_o   (sel_idx),
    .eoi_found_o (eoi_found),
    .eoi_idx_o   (eoi_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      trig_q <= '0;
      pol_q  <= '1;
      casc_q <= '0;
      fpri_q <= FPRI_RST;
      mode_q <= '0;
    end else if (reg_we_i) begin
      case (waddr)
        A_MASK_LO: mask_q[7:0]  <= reg_wdata_i;
        A_MASK_HI: mask_q[15:8] <= reg_wdata_i;
        A_TRIG_LO: trig_q[7:0]  <= reg_wdata_i;
        A_TRIG_HI: trig_q[15:8] <= reg_wdata_i;
        A_POL_LO:  pol_q[7:0]   <= reg_wdata_i;
        A_POL_HI:  pol_q[15:8]  <= reg_wdata_i;
        A_CASC_LO: casc_q[7:0]  <= reg_wdata_i;
        A_CASC_HI: casc_q[15:8] <= reg_wdata_i;
        A_FPRI_LO: fpri_q[7:0]  <= reg_wdata_i;
        A_FPRI_HI: fpri_q[15:8] <= reg_wdata_i;
        A_MODE:    mode_q       <= reg_wdata_i[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      insv_q <= '0;
      int_q  <= 1'b0;
    end else begin
      insv_q <= (insv_q & ~eoi_oh) | ack_oh;
      int_q  <= ack_i ? 1'b0 : req;
    end
  end

  always_comb begin
    case (raddr)
      A_PEND_LO: rd_data_o = pend_w[7:0];
      A_PEND_HI: rd_data_o = pend_w[15:8];
      A_MASK_LO: rd_data_o = mask_q[7:0];
      A_MASK_HI: rd_data_o = mask_q[15:8];
      A_TRIG_LO: rd_data_o = trig_q[7:0];
      A_TRIG_HI: rd_data_o = trig_q[15:8];
      A_POL_LO:  rd_data_o = pol_q[7:0];
      A_POL_HI:  rd_data_o = pol_q[15:8];
      A_CASC_LO: rd_data_o = casc_q[7:0];
      A_CASC_HI: rd_data_o = casc_q[15:8];
      A_FPRI_LO: rd_data_o = fpri_q[7:0];
      A_FPRI_HI: rd_data_o = fpri_q[15:8];
      A_MODE:    rd_data_o = {6'd0, mode_q};
      A_INSV_LO: rd_data_o = insv_q[7:0];
      A_INSV_HI: rd_data_o = insv_q[15:8];
      default:   rd_data_o = 8'd0;
    endcase
  end

  assign ack_vec_o = sel_found ? {{(VEC_W-IW){1'b0}}, sel_idx} : DEFAULT_VEC;
  assign int_o     = int_q;
endmodule

// File: rtl/ictl_chk.sv
module ictl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ack_i,
  input logic [7:0]  ack_vec_o,
  input logic        int_o,
  input logic        reg_we_i,
  input logic [15:0] pend_i,
  input logic [15:0] mask_i,
  input logic [15:0] trig_i,
  input logic [15:0] insv_i,
  input logic [1:0]  mode_i
);
  assert_ack_drops_int_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !int_o);

  assert_ack_marks_insv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_vec_o != 8'hFF) |=> insv_i[$past(ack_vec_o[3:0])]);

  assert_freeze_blocks_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && !reg_we_i) |=> ((pend_i & ~$past(pend_i) & $past(trig_i)) == 16'd0));

  assert_shared_mode_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i[0] && insv_i != 16'd0) |=> !int_o);

  assert_vec_is_live_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_vec_o != 8'hFF) |-> (pend_i[ack_vec_o[3:0]] && !mask_i[ack_vec_o[3:0]]));
endmodule

bind prio_irq_ctrl ictl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ack_i     (ack_i),
  .ack_vec_o (ack_vec_o),
  .int_o     (int_o),
  .reg_we_i  (reg_we_i),
  .pend_i    (pend_w),
  .mask_i    (mask_q),
  .trig_i    (trig_q),
  .insv_i    (insv_q),
  .mode_i    (mode_q)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] irq = '0;
  logic        we = 1'b0;
  logic [3:0]  waddr = '0;
  logic [7:0]  wdata = '0;
  logic [3:0]  raddr = '0;
  logic [7:0]  rdata;
  logic        ack = 1'b0;
  logic [7:0]  vec;
  logic        int_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .reg_we_i(we), .reg_addr_i(waddr),
    .reg_wdata_i(wdata), .rd_addr_i(raddr), .rd_data_o(rdata), .ack_i(ack),
    .ack_vec_o(vec), .int_o(int_o)
  );

  // {first-priority, mask, pending, 8'h00, expected vector}
  localparam logic [63:0] VEC_TAB [8] = '{
    {16'h0001, 16'h0000, 16'h0000, 8'h00, 8'hFF},
    {16'h0001, 16'h0000, 16'h8010, 8'h00, 8'h04},
    {16'h0020, 16'h0000, 16'h8010, 8'h00, 8'h0F},
    {16'h8000, 16'h0000, 16'h0011, 8'h00, 8'h00},
    {16'h0001, 16'h0010, 16'h8010, 8'h00, 8'h0F},
    {16'h0100, 16'h0000, 16'h00C0, 8'h00, 8'h06},
    {16'h0001, 16'hFFFF, 16'hFFFF, 8'h00, 8'hFF},
    {16'h0400, 16'h0000, 16'h0C00, 8'h00, 8'h0A}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    raddr = a;
    #1 d = rdata;
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk);
    ack = 1'b1;
    #1 v = vec;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic do_reset();
    irq = '0; we = 1'b0; ack = 1'b0;
    rst_ni = 1'b0;
    step(2);
    rst_ni = 1'b1;
    step(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [7:0] v;
    do_reset();

    // R1 reset state
    chk("R1 int_o", int_o, 0);
    rd(4'd6, b); chk("R1 pol lo", b, 8'hFF);
    rd(4'd7, b); chk("R1 pol hi", b, 8'hFF);
    rd(4'd3, b); chk("R1 mask hi", b, 8'hFF);
    rd(4'd10, b); chk("R1 fpri lo", b, 8'h01);
    rd(4'd0, b); chk("R1 pend lo", b, 8'h00);
    rd(4'd14, b); chk("R1 insv lo", b, 8'h00);
    rd(4'd12, b); chk("R1 mode", b, 8'h00);

    // R5/R8 vector table
    for (int t = 0; t < 8; t++) begin
      logic [15:0] fp, mk, pd;
      {fp, mk, pd} = VEC_TAB[t][63:16];
      wr(4'd0, 8'h40); wr(4'd1, 8'h40);
      wr(4'd10, fp[7:0]); wr(4'd11, fp[15:8]);
      wr(4'd2, mk[7:0]);  wr(4'd3, mk[15:8]);
      for (int s = 0; s < 16; s++) if (pd[s]) wr(4'd0, 8'h80 | 8'(s));
      chk($sformatf("R5 vector entry %0d", t), vec, VEC_TAB[t][7:0]);
      step(1);
      chk($sformatf("R8 int entry %0d", t), int_o, ((pd & ~mk) != 0));
    end

    // R4 pending commands
    do_reset();
    wr(4'd0, 8'h83); wr(4'd1, 8'h8C);
    rd(4'd0, b); chk("R4 set lo", b, 8'h08);
    rd(4'd1, b); chk("R4 set hi", b, 8'h10);
    wr(4'd0, 8'h89);
    rd(4'd1, b); chk("R4 low addr sets bit 9", b, 8'h12);
    wr(4'd0, 8'h40);
    rd(4'd0, b); chk("R4 clear-all lo", b, 8'h00);
    rd(4'd1, b); chk("R4 clear-all keeps hi", b, 8'h12);
    wr(4'd1, 8'h0C);
    rd(4'd1, b); chk("R4 clear bit 12", b, 8'h02);
    wr(4'd1, 8'hC1);
    rd(4'd1, b); chk("R4 bit6 wins over bit7", b, 8'h00);

    // R2 level capture, freeze, polarity
    do_reset();
    wr(4'd4, 8'h04);
    irq[2] = 1'b1; step(1);
    rd(4'd0, b); chk("R2 level set", b, 8'h04);
    irq[2] = 1'b0; step(1);
    rd(4'd0, b); chk("R2 level clear", b, 8'h00);
    wr(4'd12, 8'h02);
    irq[2] = 1'b1; step(2);
    rd(4'd0, b); chk("R2 freeze blocks", b, 8'h00);
    wr(4'd12, 8'h00); step(1);
    rd(4'd0, b); chk("R2 unfreeze captures", b, 8'h04);
    wr(4'd6, 8'hFB); step(1);
    rd(4'd0, b); chk("R2 active-low high line clears", b, 8'h00);
    irq[2] = 1'b0; step(1);
    rd(4'd0, b); chk("R2 active-low low line sets", b, 8'h04);

    // R3 edge capture
    do_reset();
    irq[1] = 1'b1; step(1);
    rd(4'd0, b); chk("R3 rising edge", b, 8'h02);
    wr(4'd0, 8'h01); step(2);
    rd(4'd0, b); chk("R3 held line no re-set", b, 8'h00);
    irq[1] = 1'b0; step(1); irq[1] = 1'b1; step(1);
    rd(4'd0, b); chk("R3 new edge", b, 8'h02);
    wr(4'd0, 8'h40); wr(4'd6, 8'hFD); step(1);
    rd(4'd0, b); chk("R3 active-low no edge yet", b, 8'h00);
    irq[1] = 1'b0; step(1);
    rd(4'd0, b); chk("R3 falling edge active-low", b, 8'h02);

    // R6 acknowledge, level vs edge pending
    do_reset();
    wr(4'd2, 8'h00); wr(4'd3, 8'h00); wr(4'd4, 8'h04);
    irq[2] = 1'b1; step(1);
    do_ack(v);
    chk("R6 level vec", v, 8'h02);
    rd(4'd14, b); chk("R6 insv set", b, 8'h04);
    rd(4'd0, b); chk("R6 level stays pending", b, 8'h04);
    irq[1] = 1'b1; step(1);
    do_ack(v);
    chk("R6 edge vec", v, 8'h01);
    rd(4'd0, b); chk("R6 edge pending cleared", b, 8'h04);
    rd(4'd14, b); chk("R6 insv both", b, 8'h06);

    // R7/R8/R9/R10 nesting, cascade, EOI
    do_reset();
    wr(4'd2, 8'h00); wr(4'd3, 8'h00); wr(4'd12, 8'h01);
    wr(4'd0, 8'h84);
    do_ack(v);
    chk("R6 vec src4", v, 8'h04);
    wr(4'd0, 8'h86); step(1);
    chk("R7 lower priority blocked", int_o, 0);
    wr(4'd0, 8'h82); step(1);
    chk("R7 higher priority requests", int_o, 1);
    wr(4'd12, 8'h00); step(1);
    chk("R8 shared mode blocked by insv", int_o, 0);
    wr(4'd12, 8'h01); wr(4'd0, 8'h40); step(1);
    chk("R7 nothing pending", int_o, 0);
    wr(4'd0, 8'h84); step(1);
    chk("R7 non-cascade in-service blocked", int_o, 0);
    wr(4'd8, 8'h10); step(1);
    chk("R7 cascade re-interrupts", int_o, 1);
    do_ack(v);
    chk("R9 int drops after ack", int_o, 0);
    rd(4'd14, b); chk("R9 insv kept", b, 8'h10);
    wr(4'd0, 8'h82);
    do_ack(v);
    rd(4'd14, b); chk("R10 setup insv", b, 8'h14);
    wr(4'd10, 8'h08); wr(4'd13, 8'h00);
    rd(4'd14, b); chk("R10 EOI rotated clears 4", b, 8'h04);
    wr(4'd10, 8'h01); wr(4'd13, 8'h00);
    rd(4'd14, b); chk("R10 EOI clears 2", b, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule